// File: doc/BRIEF.md
# Result Routing and Method Send Unit

This unit handles the final stage of each instruction in a small command-macro sequencer. The sequencer presents one finished instruction at a time: its 32-bit ALU result, a 3-bit destination register index and a 3-bit result mode. The mode decides four things. It picks the value written back to the register file, which is either the result or a word taken from the parameter FIFO. It decides whether the method-address register is reloaded from the result. It decides whether a (method, data) pair is offered on the send port. It decides whether a parameter is popped.

The method-address register is 18 bits wide. The low 12 bits are the target method and the upper 6 bits are a step size. Every accepted send moves the method forward by the step size and keeps the step size. This lets a run of sends fill consecutive or strided methods without reloading the address. Each instruction is accepted through a valid/ready handshake. The unit holds the sequencer off while an instruction that both fetches and sends waits for its parameter or for the sink. A `macro_start` pulse clears the method address and the error flag before each macro runs.

Top module: `result_router`

## Requirements
- R1: Modes 0 (fetch), 3 (fetch+send result) and 5 (fetch+load address) write the popped parameter to the destination. Modes 1, 2, 4, 6 and 7 write the ALU result to it.
- R2: Mode 1 (move) writes back only. It pops no parameter, offers no send and leaves the method address unchanged.
- R3: Modes 2, 5, 6 and 7 load the method address from result[17:0] (method = bits [11:0], step = bits [17:12]). Sends from modes 6 and 7 already use the newly loaded address.
- R4: The send data is the result in modes 3 and 4, the popped parameter in mode 6, and result[17:12] zero-extended in mode 7.
- R5: An instruction whose destination index is 0 produces no register write.
- R6: After each accepted send, the method field becomes (method + step) mod 4096 and the step is kept. A step of 0 leaves the method fixed.
- R7: Modes 3 and 6 are not accepted until the parameter FIFO has data and the sink takes the send. `snd_valid` rises only once the parameter is present. No write and no pop happen while the instruction waits.
- R8: Modes 0 and 5 complete even when the FIFO is empty. They write zero and set a sticky `err_underflow`, which only `macro_start` clears.
- R9: `macro_start` sets the method address to 0 and clears `err_underflow`. No instruction is accepted in that cycle.
- R10: While `snd_valid` is high and `snd_ready` is low, the send method and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| macro_start | input | 1 | Clears method address and error at macro start |
| op_valid | input | 1 | Instruction result present |
| op_ready | output | 1 | Instruction accepted this cycle |
| op_mode | input | 3 | Result mode |
| op_dst | input | 3 | Destination register index |
| op_result | input | 32 | ALU result |
| prm_valid | input | 1 | Parameter FIFO not empty |
| prm_data | input | 32 | Parameter FIFO head |
| prm_pop | output | 1 | Pop the FIFO head |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 3 | Register write index |
| wr_data | output | 32 | Register write value |
| snd_valid | output | 1 | Send offered |
| snd_ready | input | 1 | Sink accepts send |
| snd_method | output | 12 | Send method |
| snd_data | output | 32 | Send data |
| err_underflow | output | 1 | Sticky empty-FIFO pop error |

## Verification
The handshake, the write port, the pop strobe and the send port are all combinational from the current inputs and the stored address. They are due in the same cycle the instruction is presented, so the bench drives at the falling edge and samples 1 ns later, before the next rising edge. The method-address advance and the error flag are registered and first show one cycle after acceptance. The bench observes the address through the method of the next send, and reads the flag 1 ns after the accepting rising edge. A bench-side model of the address and flag is updated only on the edges where the bench itself predicted acceptance.

// File: rtl/result_router_pkg.sv
package result_router_pkg;

  typedef enum logic [2:0] {
    RM_FETCH          = 3'd0,
    RM_MOVE           = 3'd1,
    RM_MOVE_LOAD      = 3'd2,
    RM_FETCH_SENDRES  = 3'd3,
    RM_MOVE_SENDRES   = 3'd4,
    RM_FETCH_LOAD     = 3'd5,
    RM_MOVE_LOAD_SPRM = 3'd6,
    RM_MOVE_LOAD_SINC = 3'd7
  } rmode_e;

  typedef enum logic [1:0] {
    SD_RESULT = 2'd0,
    SD_PARAM  = 2'd1,
    SD_STEP   = 2'd2
  } sndsel_e;

  typedef struct packed {
    logic    fetch;
    logic    send;
    logic    load;
    logic    wb_param;
    sndsel_e sel;
  } rflags_t;

  function automatic rflags_t decode_mode(input rmode_e m);
    rflags_t f;
    f = '{fetch: 1'b0, send: 1'b0, load: 1'b0, wb_param: 1'b0, sel: SD_RESULT};
    unique case (m)
      RM_FETCH:          begin f.fetch = 1'b1; f.wb_param = 1'b1; end
      RM_MOVE:           ;
      RM_MOVE_LOAD:      f.load = 1'b1;
      RM_FETCH_SENDRES:  begin f.fetch = 1'b1; f.wb_param = 1'b1; f.send = 1'b1; end
      RM_MOVE_SENDRES:   f.send = 1'b1;
      RM_FETCH_LOAD:     begin f.fetch = 1'b1; f.wb_param = 1'b1; f.load = 1'b1; end
      RM_MOVE_LOAD_SPRM: begin f.load = 1'b1; f.fetch = 1'b1; f.send = 1'b1; f.sel = SD_PARAM; end
      RM_MOVE_LOAD_SINC: begin f.load = 1'b1; f.send = 1'b1; f.sel = SD_STEP; end
      default:           ;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/rr_decode.sv
module rr_decode
  import result_router_pkg::*;
(
  input  logic [2:0] mode,
  output rflags_t    flags
);
  always_comb flags = decode_mode(rmode_e'(mode));
endmodule

// File: rtl/rr_method_reg.sv
module rr_method_reg #(
  parameter int MW = 12,
  parameter int IW = 6,
  localparam int AW = MW + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          commit,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          advance,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] eff_addr
);
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a;
    r[MW-1:0] = a[MW-1:0] + {{(MW-IW){1'b0}}, a[AW-1:MW]};
    return r;
  endfunction

  assign eff_addr = load ? load_val : cur_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cur_addr <= '0;
    else if (clear)      cur_addr <= '0;
    else if (commit)     cur_addr <= advance ? step_addr(eff_addr) : eff_addr;
  end
endmodule

// File: rtl/rr_send_mux.sv
module rr_send_mux
  import result_router_pkg::*;
#(
  parameter int DW = 32,
  parameter int MW = 12,
  parameter int IW = 6,
  localparam int AW = MW + IW
) (
  input  sndsel_e       sel,
  input  logic [DW-1:0] result,
  input  logic [DW-1:0] param,
  output logic [DW-1:0] data
);
  always_comb begin
    unique case (sel)
      SD_PARAM: data = param;
      SD_STEP:  data = {{(DW-IW){1'b0}}, result[AW-1:MW]};
      default:  data = result;
    endcase
  end
endmodule

// File: rtl/result_router.sv
module result_router
  import result_router_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 3,
  parameter int MW = 12,
  parameter int IW = 6,
  localparam int AW = MW + IW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          macro_start,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [2:0]    op_mode,
  input  logic [RW-1:0] op_dst,
  input  logic [DW-1:0] op_result,
  input  logic          prm_valid,
  input  logic [DW-1:0] prm_data,
  output logic          prm_pop,
  output logic          wr_en,
  output logic [RW-1:0] wr_idx,
  output logic [DW-1:0] wr_data,
  output logic          snd_valid,
  input  logic          snd_ready,
  output logic [MW-1:0] snd_method,
  output logic [DW-1:0] snd_data,
  output logic          err_underflow
);
  rflags_t       fl;
  logic          commit;
  logic          fire_send;
  logic          underflow_ev;
  logic [DW-1:0] fetched;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] eff_addr;
  logic [IW-1:0] send_incr;

  rr_decode u_dec (.mode(op_mode), .flags(fl));

  // A fetch paired with a send waits for data; a lone fetch never waits.
  assign op_ready  = !macro_start
                   && (!fl.send || snd_ready)
                   && (!(fl.fetch && fl.send) || prm_valid);
  assign commit    = op_valid && op_ready;
  assign snd_valid = op_valid && !macro_start && fl.send && (!fl.fetch || prm_valid);
  assign fire_send = snd_valid && snd_ready;

  assign fetched      = prm_valid ? prm_data : '0;
  assign prm_pop      = commit && fl.fetch && prm_valid;
  assign underflow_ev = commit && fl.fetch && !prm_valid;

  assign wr_en   = commit && (op_dst != '0);
  assign wr_idx  = op_dst;
  assign wr_data = fl.wb_param ? fetched : op_result;

  rr_method_reg #(.MW(MW), .IW(IW)) u_maddr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (macro_start),
    .commit   (commit),
    .load     (fl.load),
    .load_val (op_result[AW-1:0]),
    .advance  (fl.send),
    .cur_addr (cur_addr),
    .eff_addr (eff_addr)
  );

  assign snd_method = eff_addr[MW-1:0];
  assign send_incr  = eff_addr[AW-1:MW];

  rr_send_mux #(.DW(DW), .MW(MW), .IW(IW)) u_smux (
    .sel    (fl.sel),
    .result (op_result),
    .param  (fetched),
    .data   (snd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            err_underflow <= 1'b0;
    else if (macro_start)  err_underflow <= 1'b0;
    else if (underflow_ev) err_underflow <= 1'b1;
  end
endmodule

// File: rtl/result_router_chk.sv
module result_router_chk #(
  parameter int RW = 3,
  parameter int DW = 32,
  parameter int MW = 12,
  parameter int IW = 6,
  localparam int AW = MW + IW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          macro_start,
  input logic          op_valid,
  input logic [2:0]    op_mode,
  input logic          prm_valid,
  input logic          prm_pop,
  input logic          wr_en,
  input logic [RW-1:0] wr_idx,
  input logic          snd_valid,
  input logic          snd_ready,
  input logic [MW-1:0] snd_method,
  input logic [DW-1:0] snd_data,
  input logic          err_underflow,
  input logic          fire_send,
  input logic [IW-1:0] send_incr,
  input logic [AW-1:0] cur_addr
);
  logic [MW-1:0] adv_exp;
  assign adv_exp = snd_method + {{(MW-IW){1'b0}}, send_incr};

  a_r5_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_idx != '0);

  a_r2_move_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode == 3'd1) |-> (!prm_pop && !snd_valid));

  a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    prm_pop |-> prm_valid);

  a_r6_step_after_send: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_send && !macro_start) |=> cur_addr[MW-1:0] == $past(adv_exp));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_underflow && !macro_start) |=> err_underflow);

  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    macro_start |=> (!err_underflow && cur_addr == '0));

  a_r10_send_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && !snd_ready && !macro_start) |=>
      (snd_valid && $stable(snd_method) && $stable(snd_data)));
endmodule

bind result_router result_router_chk #(.RW(RW), .DW(DW), .MW(MW), .IW(IW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .macro_start   (macro_start),
  .op_valid      (op_valid),
  .op_mode       (op_mode),
  .prm_valid     (prm_valid),
  .prm_pop       (prm_pop),
  .wr_en         (wr_en),
  .wr_idx        (wr_idx),
  .snd_valid     (snd_valid),
  .snd_ready     (snd_ready),
  .snd_method    (snd_method),
  .snd_data      (snd_data),
  .err_underflow (err_underflow),
  .fire_send     (fire_send),
  .send_incr     (send_incr),
  .cur_addr      (cur_addr)
);

// File: tb/result_router_bench.sv
module result_router_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        macro_start = 1'b0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [2:0]  op_mode = '0;
  logic [2:0]  op_dst = '0;
  logic [31:0] op_result = '0;
  logic        prm_valid = 1'b0;
  logic [31:0] prm_data = '0;
  logic        prm_pop;
  logic        wr_en;
  logic [2:0]  wr_idx;
  logic [31:0] wr_data;
  logic        snd_valid;
  logic        snd_ready = 1'b0;
  logic [11:0] snd_method;
  logic [31:0] snd_data;
  logic        err_underflow;

  int n_cmp = 0;
  int n_bad = 0;
  logic [17:0] m_addr = '0;
  logic        m_err = 1'b0;

  always #5 clk = ~clk;

  result_router u_result_router (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Present one instruction for one cycle, check all outputs, then update the model.
  task automatic op(input int m, input int d, input logic [31:0] res,
                    input logic pv, input logic [31:0] pd, input logic sr);
    logic fetch, send, load, rdy, wbp, sv;
    logic [17:0] base;
    logic [31:0] fv, sdat;
    @(negedge clk);
    op_valid = 1'b1; op_mode = 3'(m); op_dst = 3'(d); op_result = res;
    prm_valid = pv; prm_data = pd; snd_ready = sr;
    fetch = (m == 0) || (m == 3) || (m == 5) || (m == 6);
    send  = (m == 3) || (m == 4) || (m >= 6);
    load  = (m == 2) || (m >= 5);
    wbp   = (m == 0) || (m == 3) || (m == 5);
    rdy   = (!send || sr) && !(fetch && send && !pv);
    sv    = send && (!fetch || pv);
    fv    = pv ? pd : 32'd0;
    base  = load ? res[17:0] : m_addr;
    sdat  = (m == 6) ? fv : (m == 7) ? {26'd0, res[17:12]} : res;
    #1;
    chk("R7 ready", {31'd0, op_ready}, {31'd0, rdy});
    chk("R7 send_valid", {31'd0, snd_valid}, {31'd0, sv});
    chk("R2/R7 pop", {31'd0, prm_pop}, {31'd0, rdy && fetch && pv});
    chk("R5 wr_en", {31'd0, wr_en}, {31'd0, rdy && d != 0});
    if (rdy && d != 0) begin
      chk("R1 wr_idx", {29'd0, wr_idx}, d);
      chk(wbp ? "R1/R8 wr_data param" : "R1 wr_data result", wr_data, wbp ? fv : res);
    end
    if (sv) begin
      chk("R3/R6 snd_method", {20'd0, snd_method}, {20'd0, base[11:0]});
      chk("R4 snd_data", snd_data, sdat);
    end
    @(posedge clk);
    if (rdy) begin
      m_addr = base;
      if (send) m_addr[11:0] = base[11:0] + {6'd0, base[17:12]};
      if (fetch && !pv) m_err = 1'b1;
    end
    #1;
    chk("R8 err", {31'd0, err_underflow}, {31'd0, m_err});
    op_valid = 1'b0;
  endtask

  task automatic start_pulse();
    @(negedge clk);
    macro_start = 1'b1; op_valid = 1'b1; op_mode = 3'd1; op_dst = 3'd2;
    #1;
    chk("R9 no accept during start", {31'd0, op_ready}, 32'd0);
    chk("R9 no write during start", {31'd0, wr_en}, 32'd0);
    @(posedge clk);
    #1;
    macro_start = 1'b0; op_valid = 1'b0;
    m_addr = '0; m_err = 1'b0;
    chk("R9 err cleared", {31'd0, err_underflow}, 32'd0);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #12;
    chk("R9 reset err", {31'd0, err_underflow}, 32'd0);
    chk("R5 reset wr_en", {31'd0, wr_en}, 32'd0);
    chk("R7 reset snd_valid", {31'd0, snd_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    start_pulse();

    // Sweep every mode and destination with data present and sink ready.
    for (int m = 0; m < 8; m++)
      for (int d = 0; d < 8; d++)
        op(m, d, ((m * 8 + d) * 32'h0123_4567) ^ 32'h0003_3FF0, 1'b1,
           32'hA500_0000 + (m * 8 + d), 1'b1);

    // R6: wrap of the method field modulo 4096.
    op(2, 1, 32'h0000_3FFE, 1'b0, 32'd0, 1'b1);
    op(4, 1, 32'hDEAD_0001, 1'b0, 32'd0, 1'b1);
    op(4, 2, 32'hDEAD_0002, 1'b0, 32'd0, 1'b1);
    // R6: step of zero keeps the method.
    op(2, 3, 32'h0000_0123, 1'b0, 32'd0, 1'b1);
    op(4, 3, 32'h1111_1111, 1'b0, 32'd0, 1'b1);
    op(4, 3, 32'h2222_2222, 1'b0, 32'd0, 1'b1);
    // R2: a move leaves the address alone, confirmed by the next send.
    op(1, 4, 32'h0005_5555, 1'b1, 32'h7777_7777, 1'b1);
    op(4, 4, 32'h3333_3333, 1'b0, 32'd0, 1'b1);

    // R7/R10: fetch+send stalls on empty FIFO, then on a busy sink.
    op(3, 5, 32'h0001_2345, 1'b0, 32'd0, 1'b1);
    op(3, 5, 32'h0001_2345, 1'b1, 32'hCAFE_0001, 1'b0);
    op(3, 5, 32'h0001_2345, 1'b1, 32'hCAFE_0001, 1'b0);
    op(3, 5, 32'h0001_2345, 1'b1, 32'hCAFE_0001, 1'b1);
    op(6, 6, 32'h0002_0010, 1'b0, 32'd0, 1'b1);
    op(6, 6, 32'h0002_0010, 1'b1, 32'hBEEF_0002, 1'b0);
    op(6, 6, 32'h0002_0010, 1'b1, 32'hBEEF_0002, 1'b1);
    op(7, 7, 32'h0003_F100, 1'b0, 32'd0, 1'b0);
    op(7, 7, 32'h0003_F100, 1'b0, 32'd0, 1'b1);

    // R8: lone fetch on empty FIFO writes zero and sets the sticky flag.
    op(0, 2, 32'h1234_5678, 1'b0, 32'd0, 1'b1);
    op(1, 2, 32'h0000_0042, 1'b1, 32'h1, 1'b1);
    op(5, 3, 32'h0004_1000, 1'b0, 32'd0, 1'b0);
    op(4, 3, 32'h5555_5555, 1'b0, 32'd0, 1'b1);

    // R9: start clears flag and address.
    start_pulse();
    op(4, 1, 32'h6666_6666, 1'b0, 32'd0, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule